// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive FIFO

This block is the receive half of an asynchronous serial port. The input line passes through a two-flop synchronizer. It is then sampled at sixteen ticks per bit period, with the tick rate derived from a 16-bit divisor. Each bit is resolved by a 2-of-3 majority vote over three samples taken around the bit centre.

A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. Each valid byte is pushed into an eight-entry first-in first-out buffer. The host reads the head of the buffer through a 32-bit data word and removes it with a pop strobe. A watermark flag tells the host when the buffer holds more entries than a programmed threshold.

The host controls an enable input. While the enable is low, the receiver stays idle and accepts nothing. Bytes already held in the buffer can still be read.

Top module: `rx_oversample_fifo`

## Requirements
- R1: The oversample tick period is floor((divisor+1)/16) clock cycles, with a minimum of one cycle. One bit period lasts 16 ticks.
- R2: While idle, the receiver checks the synchronized line on every tick. A low level starts a frame. If the start bit votes high at its centre, the frame is dropped as a glitch, no byte is stored, and the receiver returns to idle.
- R3: Each bit value is the 2-of-3 majority of the samples taken at oversample ticks 7, 8 and 9 of that bit. A single disturbed sample does not change the result.
- R4: A frame is start (low), eight data bits least significant bit first, and a stop bit. The byte is stored only if the stop bit votes high.
- R5: While rxEnable is low, any frame in progress is abandoned and no new frame is received.
- R6: The buffer holds up to 8 bytes and returns them in arrival order. A pop while the buffer is empty has no effect.
- R7: rxWord carries the empty flag in bit 31 (1 = empty) and the head byte in bits 7:0. Bits 30:8 read as zero, and bits 7:0 read as zero while the buffer is empty.
- R8: A byte that completes while the buffer holds 8 entries is discarded. The stored contents are unchanged.
- R9: wmFlag is high exactly while the entry count is strictly greater than wmThreshold. After reset the buffer is empty and wmFlag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive channel enable |
| divisor | input | 16 | Baud divisor; tick period is (divisor+1)/16 cycles |
| wmThreshold | input | 3 | Watermark threshold |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| popReq | input | 1 | Removes the head entry for one cycle |
| rxWord | output | 32 | Bit 31 is the empty flag; bits 7:0 are the head byte |
| wmFlag | output | 1 | Count is greater than the threshold |

## Verification
The assertions assume that popReq is a single-cycle strobe driven between clock edges. They also assume that divisor and wmThreshold change only while the receiver is idle, so that a tick window or watermark comparison is never cut short in the middle of a frame. The stimulus changes rxLine only at whole bit boundaries, except for deliberate two-cycle disturbances. It sets the divisor only between frames. It raises popReq only after reading the head word. This keeps every sampled bit window well defined.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_e;

  typedef struct packed {
    logic takeSample;
    logic shiftBit;
    logic pushByte;
  } rxStrobe_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxEnable,
  input  logic [DIV_W-1:0] divisor,
  input  logic             lineSync,
  input  logic             voteBit,
  output rxStrobe_t        strobes
);
  localparam int PER_W = DIV_W + 1;
  localparam int OVS_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [OVS_W-1:0] SAMP_FIRST = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] SAMP_LAST  = OVS_W'(OVS / 2 + 1);
  localparam logic [OVS_W-1:0] DECIDE     = OVS_W'(OVS / 2 + 2);
  localparam logic [OVS_W-1:0] OVS_LAST   = OVS_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(DATA_BITS - 1);

  logic [PER_W-1:0] divPlus, period, tickCnt;
  logic             tick;
  rxState_e         state;
  logic [OVS_W-1:0] ovsCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             atDecide, atWrap;

  // R1: tick period from divisor, never below one cycle
  always_comb begin
    divPlus = {1'b0, divisor} + PER_W'(1);
    period  = divPlus >> OVS_W;
    if (period == '0) period = PER_W'(1);
  end

  assign tick = (tickCnt >= period - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else tickCnt <= tickCnt + PER_W'(1);
  end

  assign atDecide = tick && (ovsCnt == DECIDE);
  assign atWrap   = tick && (ovsCnt == OVS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ovsCnt <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      state  <= ST_IDLE;
      ovsCnt <= '0;
    end else if (state == ST_IDLE) begin
      if (tick && !lineSync) begin
        state  <= ST_START;
        ovsCnt <= OVS_W'(1);
      end
    end else begin
      if (tick) ovsCnt <= (ovsCnt == OVS_LAST) ? '0 : ovsCnt + OVS_W'(1);
      if (state == ST_START) begin
        if (atDecide && voteBit) state <= ST_IDLE;
        else if (atWrap) begin
          state  <= ST_DATA;
          bitIdx <= '0;
        end
      end else if (state == ST_DATA) begin
        if (atWrap) begin
          if (bitIdx == IDX_LAST) state <= ST_STOP;
          else bitIdx <= bitIdx + IDX_W'(1);
        end
      end else begin
        if (atDecide) state <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strobes.takeSample = rxEnable && tick && (state != ST_IDLE) &&
                         (ovsCnt >= SAMP_FIRST) && (ovsCnt <= SAMP_LAST);
    strobes.shiftBit   = rxEnable && (state == ST_DATA) && atDecide;
    strobes.pushByte   = rxEnable && (state == ST_STOP) && atDecide && voteBit;
  end

  // R5: disable forces idle on the next cycle
  a_r5_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (state == ST_IDLE));

  // R2: a frame only starts from a low synchronized line
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) == ST_IDLE) |-> !$past(lineSync));

  // R4: a byte is pushed only when the stop bit is voted high
  a_r4_push_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pushByte |-> voteBit);

  // R3: samples are never taken while idle
  a_r3_no_idle_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !strobes.takeSample);
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 8,
  parameter int THR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  rxStrobe_t         strobes,
  input  logic              popReq,
  input  logic [THR_W-1:0]  wmThreshold,
  output logic              lineSync,
  output logic              voteBit,
  output logic [WORD_W-1:0] rxWord,
  output logic              wmFlag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [1:0]           syncFf;
  logic [2:0]           samples;
  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;
  logic                 doPush, doPop, isEmpty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncFf <= 2'b11;
    else syncFf <= {syncFf[0], rxLine};
  end
  assign lineSync = syncFf[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samples <= 3'b111;
    else if (strobes.takeSample) samples <= {samples[1:0], lineSync};
  end

  assign voteBit = (samples[0] & samples[1]) | (samples[0] & samples[2]) |
                   (samples[1] & samples[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {voteBit, shiftReg[DATA_BITS-1:1]};
  end

  assign isEmpty = (count == '0);
  assign doPush  = strobes.pushByte && (count != FULL_CNT);
  assign doPop   = popReq && !isEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rxWord = {isEmpty, {(WORD_W-1-DATA_BITS){1'b0}},
                   isEmpty ? {DATA_BITS{1'b0}} : mem[rdPtr]};
  assign wmFlag = (count > CNT_W'(wmThreshold));

  // R6: count never exceeds capacity
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8: a full buffer stays full without a pop
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && !popReq) |=> (count == FULL_CNT));

  // R6: pop on empty leaves it empty
  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (isEmpty && popReq && !strobes.pushByte) |=> (count == '0));

  // R7: empty word carries a zero data field
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rxWord[WORD_W-1] |-> (rxWord[DATA_BITS-1:0] == '0));
endmodule

// File: rtl/rx_oversample_fifo.sv
module rx_oversample_fifo
  import rx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 8,
  parameter int THR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [THR_W-1:0]  wmThreshold,
  input  logic              rxLine,
  input  logic              popReq,
  output logic [WORD_W-1:0] rxWord,
  output logic              wmFlag
);
  rxStrobe_t strobes;
  logic      lineSync, voteBit;

  rx_ctrl #(.DIV_W(DIV_W), .OVS(OVS), .DATA_BITS(DATA_BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .divisor(divisor),
    .lineSync(lineSync), .voteBit(voteBit), .strobes(strobes)
  );

  rx_datapath #(.DATA_BITS(DATA_BITS), .DEPTH(DEPTH), .THR_W(THR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .strobes(strobes),
    .popReq(popReq), .wmThreshold(wmThreshold), .lineSync(lineSync),
    .voteBit(voteBit), .rxWord(rxWord), .wmFlag(wmFlag)
  );
endmodule

// File: tb/rx_oversample_fifo_tb_top.sv
module rx_oversample_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxEnable = 1'b1;
  logic [15:0] divisor = 16'd31;
  logic [2:0]  wmThreshold = 3'd7;
  logic        rxLine = 1'b1;
  logic        popReq = 1'b0;
  logic [31:0] rxWord;
  logic        wmFlag;

  int checks = 0;
  int errors = 0;
  int bitClks = 32;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_oversample_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .divisor(divisor),
    .wmThreshold(wmThreshold), .rxLine(rxLine), .popReq(popReq),
    .rxWord(rxWord), .wmFlag(wmFlag)
  );

  task automatic checkWord(input string req, input logic [31:0] exp);
    checks++;
    if (rxWord !== exp) begin
      errors++;
      $display("FAIL %s rxWord actual %h expected %h", req, rxWord, exp);
    end
  endtask

  task automatic checkWm(input string req, input logic exp);
    checks++;
    if (wmFlag !== exp) begin
      errors++;
      $display("FAIL %s wmFlag actual %b expected %b", req, wmFlag, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopVal, input logic [7:0] glitchMask);
    for (int k = 0; k < 10; k++) begin
      logic val;
      val = (k == 0) ? 1'b0 : (k == 9) ? stopVal : b[k-1];
      for (int c = 0; c < bitClks; c++) begin
        if (k >= 1 && k <= 8 && glitchMask[k-1] &&
            (c == bitClks / 2 + 2 || c == bitClks / 2 + 3))
          rxLine = ~val;
        else
          rxLine = val;
        @(negedge clk);
      end
    end
    rxLine = 1'b1;
    repeat (bitClks) @(negedge clk);
  endtask

  task automatic popOne();
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [7:0] b);
    return {24'h0, b};
  endfunction

  task automatic testReset();
    checkWord("R7 reset empty", 32'h8000_0000);
    checkWm("R9 reset wm low", 1'b0);
  endtask

  task automatic testBasic();
    divisor = 16'd31; bitClks = 32;
    sendFrame(8'hA5, 1'b1, 8'h00);
    checkWord("R4 byte A5", word(8'hA5));
    popOne();
    checkWord("R6 empty after pop", 32'h8000_0000);
  endtask

  task automatic testDivisors();
    divisor = 16'd15; bitClks = 16;
    sendFrame(8'h3C, 1'b1, 8'h00);
    checkWord("R1 divisor 15", word(8'h3C));
    popOne();
    divisor = 16'd47; bitClks = 48;
    sendFrame(8'h81, 1'b1, 8'h00);
    checkWord("R1 divisor 47", word(8'h81));
    popOne();
    divisor = 16'd31; bitClks = 32;
  endtask

  task automatic testGlitch();
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (400) @(negedge clk);
    checkWord("R2 short low rejected", 32'h8000_0000);
  endtask

  task automatic testBadStop();
    sendFrame(8'h55, 1'b0, 8'h00);
    repeat (400) @(negedge clk);
    checkWord("R4 bad stop dropped", 32'h8000_0000);
  endtask

  task automatic testDisabled();
    rxEnable = 1'b0;
    sendFrame(8'h12, 1'b1, 8'h00);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    checkWord("R5 disabled no byte", 32'h8000_0000);
  endtask

  task automatic testVote();
    sendFrame(8'hF0, 1'b1, 8'h81);
    checkWord("R3 single sample disturbed", word(8'hF0));
    popOne();
  endtask

  task automatic testFillOverflow();
    wmThreshold = 3'd3;
    for (int i = 0; i < 9; i++) begin
      sendFrame(8'h10 + 8'(i), 1'b1, 8'h00);
      if (i == 2) checkWm("R9 count 3 not above 3", 1'b0);
      if (i == 3) checkWm("R9 count 4 above 3", 1'b1);
    end
    checkWord("R8 head kept after overflow", word(8'h10));
    for (int i = 0; i < 8; i++) begin
      checkWord("R6 FIFO order", word(8'h10 + 8'(i)));
      popOne();
      if (i == 4) checkWm("R9 count 3 after pops", 1'b0);
    end
    checkWord("R8 ninth byte discarded", 32'h8000_0000);
    popOne();
    checkWord("R6 pop on empty ignored", 32'h8000_0000);
    sendFrame(8'h6E, 1'b1, 8'h00);
    checkWord("R6 pointers intact after empty pop", word(8'h6E));
    popOne();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testBasic();
    testDivisors();
    testGlitch();
    testBadStop();
    testDisabled();
    testVote();
    testFillOverflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule